// File: doc/BRIEF.md
# Dual-edge carry-save counter

This block is a free-running counter for time-stamping. It steps on both edges of a fast clock, so one count is one half-cycle. Each stored bit is a pseudo-dual-edge element: a rising-edge flop and a falling-edge flop. The bit's value is the XOR of the two flops. To update on an edge, the flop that owns that edge loads the wanted value XOR the other flop's output.

The counter bits are half-adder cells. Each cell registers its sum and its carry on their own, so a carry moves up only one bit per count step and no ripple chain sits in the fast path. The value at any moment is the saved-sum vector plus the saved-carry vector, modulo 2^WIDTH. A parameter picks a single-edge variant, which steps on rising edges only, for comparison.

A slower reader turns the count into plain binary. On a snapshot strobe it copies both saved vectors and then adds them CHUNK bits per clock. The reader has three states. In IDLE it waits for a strobe. SUM runs one chunk per cycle. SHOW presents the result for one cycle. The transitions are: IDLE to SUM on a strobe (capture); SUM to SUM while chunks remain; SUM to SHOW on the last chunk; SHOW to IDLE always. Any state goes to IDLE when clear is high.

Top module: `dcs_counter`

## Requirements
- R1: With DUAL_EDGE=1 the count increases by one on every rising and every falling edge of clk.
- R2: With DUAL_EDGE=0 the count increases by one on every rising edge only, and falling edges leave it unchanged.
- R3: The resolved value is exactly the binary number of counting edges, including values where many carries are still pending in saved form (for example 255 after 255 edges).
- R4: An edge that samples clr high makes the count zero. The first counting edge after clr falls gives a count of 1.
- R5: The count wraps modulo 2^WIDTH.
- R6: A snapshot strobe sampled high on a rising edge while the reader is in IDLE captures the count as it stood just before that edge's own increment.
- R7: cnt_rdy_o is high for exactly one clock cycle. It follows the WIDTH/CHUNK-th rising edge after the capture edge. cnt_o changes only on the edge that raises cnt_rdy_o, or on a clear.
- R8: A strobe sampled while the reader is in SUM or SHOW is ignored. With the strobe held high, captures therefore repeat every WIDTH/CHUNK+2 rising edges.
- R9: A rising edge that samples clr high returns the reader to IDLE and sets cnt_o to zero. Any resolve in progress is dropped, so no cnt_rdy_o pulse follows.
- R10: Bit N of the count toggles every 2^N half-cycles in dual-edge mode, so its period is 2^(N+1) half-cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast counting clock |
| clr | input | 1 | Synchronous clear, sampled on every counting edge |
| snap | input | 1 | Snapshot strobe, sampled on rising edges |
| cnt_o | output | WIDTH | Resolved binary count of the last snapshot |
| cnt_rdy_o | output | 1 | One-cycle flag: cnt_o has just been updated |

## Verification
A wrong bit in the saved sum or saved carry vectors does not show at the ports until the next snapshot. It then appears WIDTH/CHUNK+1 cycles after the strobe, as a resolved value that disagrees with the count of edges. A carry dropped or duplicated inside a cell shows the same way, as a fixed offset in every later snapshot until the next clear. A reader state fault shows within a cycle or two: a missing or doubled cnt_rdy_o pulse, or a strobe wrongly accepted during SUM or SHOW.

// File: rtl/dcs_pkg.sv
`timescale 1ns/1ps
package dcs_pkg;
    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_SUM  = 2'd1,
        RD_SHOW = 2'd2
    } rd_state_e;
endpackage

// File: rtl/dcs_pde_bit.sv
`timescale 1ns/1ps
// One storage bit. Dual-edge variant: value is rise_q ^ fall_q; each edge's
// flop loads (wanted value ^ partner flop) so the XOR becomes the wanted value.
module dcs_pde_bit #(
    parameter bit DUAL_EDGE = 1'b1
) (
    input  logic clk,
    input  logic d,
    output logic q
);
    if (DUAL_EDGE) begin : g_dual
        logic rise_q;
        logic fall_q;
        always_ff @(posedge clk) rise_q <= d ^ fall_q;
        always_ff @(negedge clk) fall_q <= d ^ rise_q;
        assign q = rise_q ^ fall_q;
    end else begin : g_single
        logic hold_q;
        always_ff @(posedge clk) hold_q <= d;
        assign q = hold_q;
    end
endmodule

// File: rtl/dcs_ha_cell.sv
`timescale 1ns/1ps
// Half-adder cell with registered sum and registered carry-out.
module dcs_ha_cell #(
    parameter bit DUAL_EDGE = 1'b1
) (
    input  logic clk,
    input  logic clr,
    input  logic cin,
    output logic sum_o,
    output logic cout_o
);
    logic s_d;
    logic c_d;

    always_comb begin
        s_d = clr ? 1'b0 : (sum_o ^ cin);
        c_d = clr ? 1'b0 : (sum_o & cin);
    end

    dcs_pde_bit #(.DUAL_EDGE(DUAL_EDGE)) u_sum (
        .clk(clk), .d(s_d), .q(sum_o)
    );
    dcs_pde_bit #(.DUAL_EDGE(DUAL_EDGE)) u_cry (
        .clk(clk), .d(c_d), .q(cout_o)
    );
endmodule

// File: rtl/dcs_csa_core.sv
`timescale 1ns/1ps
// Carry-save counting array. cry_o[i] carries weight 2^i; bit 0 is always 0.
module dcs_csa_core #(
    parameter int WIDTH     = 32,
    parameter bit DUAL_EDGE = 1'b1
) (
    input  logic             clk,
    input  logic             clr,
    output logic [WIDTH-1:0] sum_o,
    output logic [WIDTH-1:0] cry_o
);
    logic [WIDTH-1:0] inc;

    // The increment enters at bit 0; higher bits take the saved carry.
    assign inc      = {cry_o[WIDTH-1:1], 1'b1};
    assign cry_o[0] = 1'b0;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i < WIDTH - 1) begin : g_cell
            dcs_ha_cell #(.DUAL_EDGE(DUAL_EDGE)) u_cell (
                .clk    (clk),
                .clr    (clr),
                .cin    (inc[i]),
                .sum_o  (sum_o[i]),
                .cout_o (cry_o[i+1])
            );
        end else begin : g_top
            // Top bit: its carry-out is the wrap and is dropped.
            logic top_d;
            assign top_d = clr ? 1'b0 : (sum_o[i] ^ inc[i]);
            dcs_pde_bit #(.DUAL_EDGE(DUAL_EDGE)) u_top (
                .clk(clk), .d(top_d), .q(sum_o[i])
            );
        end
    end

    // Checks on the combined value of the two saved vectors.
    logic [1:0]       age_q;
    logic [WIDTH-1:0] tot;
    always_ff @(posedge clk) age_q <= {age_q[0], 1'b1};
    assign tot = sum_o + cry_o;

    if (DUAL_EDGE) begin : g_chk_dual
        logic clr_nq;
        always_ff @(negedge clk) clr_nq <= clr;

        p_two_steps_r1: assert property (@(posedge clk) disable iff (clr)
            (age_q[1] && !$past(clr) && !clr_nq) |-> (tot == $past(tot) + WIDTH'(2)));

        p_clear_zero_r4: assert property (@(posedge clk) disable iff (clr)
            (age_q[1] && $past(clr) && clr_nq) |-> (tot == '0));
    end else begin : g_chk_single
        p_one_step_r2: assert property (@(posedge clk) disable iff (clr)
            (age_q[1] && !$past(clr)) |-> (tot == $past(tot) + WIDTH'(1)));

        p_clear_zero_r4: assert property (@(posedge clk) disable iff (clr)
            (age_q[1] && $past(clr)) |-> (tot == '0));
    end
endmodule

// File: rtl/dcs_reader.sv
`timescale 1ns/1ps
// Snapshot reader: copies both saved vectors, adds them CHUNK bits per cycle.
module dcs_reader
    import dcs_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int CHUNK = 8
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             snap,
    input  logic [WIDTH-1:0] sum_i,
    input  logic [WIDTH-1:0] cry_i,
    output logic [WIDTH-1:0] val_o,
    output logic             rdy_o
);
    localparam int NCH  = WIDTH / CHUNK;
    localparam int IDXW = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [IDXW-1:0] IDX_LAST = IDXW'(NCH - 1);

    rd_state_e              st_q;
    rd_state_e              st_d;
    logic [WIDTH-1:0]       a_q;
    logic [WIDTH-1:0]       b_q;
    logic [WIDTH-CHUNK-1:0] acc_q;
    logic [WIDTH-1:0]       out_q;
    logic [IDXW-1:0]        idx_q;
    logic                   cy_q;
    logic [CHUNK:0]         part;
    logic [WIDTH-1:0]       acc_nx;

    assign part   = {1'b0, a_q[CHUNK-1:0]} + {1'b0, b_q[CHUNK-1:0]}
                  + {{CHUNK{1'b0}}, cy_q};
    assign acc_nx = {part[CHUNK-1:0], acc_q};

    // Next state.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RD_IDLE: if (snap) st_d = RD_SUM;
            RD_SUM:  if (idx_q == IDX_LAST) st_d = RD_SHOW;
            RD_SHOW: st_d = RD_IDLE;
            default: st_d = RD_IDLE;
        endcase
        if (clr) st_d = RD_IDLE;
    end

    // State register.
    always_ff @(posedge clk) st_q <= st_d;

    // Datapath.
    always_ff @(posedge clk) begin
        if (clr) begin
            out_q <= '0;
            idx_q <= '0;
            cy_q  <= 1'b0;
        end else begin
            case (st_q)
                RD_IDLE: if (snap) begin
                    a_q   <= sum_i;
                    b_q   <= cry_i;
                    idx_q <= '0;
                    cy_q  <= 1'b0;
                end
                RD_SUM: begin
                    a_q   <= a_q >> CHUNK;
                    b_q   <= b_q >> CHUNK;
                    acc_q <= acc_nx[WIDTH-1:CHUNK];
                    cy_q  <= part[CHUNK];
                    idx_q <= idx_q + IDXW'(1);
                    if (idx_q == IDX_LAST) out_q <= acc_nx;
                end
                default: ;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        rdy_o = (st_q == RD_SHOW);
        val_o = out_q;
    end

    p_show_pulse_r7: assert property (@(posedge clk) disable iff (clr)
        rdy_o |=> !rdy_o);

    p_result_hold_r7: assert property (@(posedge clk) disable iff (clr)
        (!$past(clr) && !$rose(rdy_o)) |-> $stable(val_o));

    p_busy_no_restart_r8: assert property (@(posedge clk) disable iff (clr)
        (st_q == RD_SUM) |=> (st_q != RD_IDLE));
endmodule

// File: rtl/dcs_counter.sv
`timescale 1ns/1ps
module dcs_counter #(
    parameter int WIDTH     = 32,
    parameter bit DUAL_EDGE = 1'b1,
    parameter int CHUNK     = 8
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             snap,
    output logic [WIDTH-1:0] cnt_o,
    output logic             cnt_rdy_o
);
    logic [WIDTH-1:0] sum_v;
    logic [WIDTH-1:0] cry_v;

    dcs_csa_core #(.WIDTH(WIDTH), .DUAL_EDGE(DUAL_EDGE)) u_core (
        .clk   (clk),
        .clr   (clr),
        .sum_o (sum_v),
        .cry_o (cry_v)
    );

    dcs_reader #(.WIDTH(WIDTH), .CHUNK(CHUNK)) u_rd (
        .clk   (clk),
        .clr   (clr),
        .snap  (snap),
        .sum_i (sum_v),
        .cry_i (cry_v),
        .val_o (cnt_o),
        .rdy_o (cnt_rdy_o)
    );
endmodule

// File: tb/sim_dcs_counter.sv
`timescale 1ns/1ps
module sim_dcs_counter;
    localparam int W   = 12;
    localparam int CH  = 4;
    localparam int NCH = W / CH;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic clr  = 1'b1;
    logic snap = 1'b0;
    logic [W-1:0] cnt0, cnt1;
    logic rdy0, rdy1;

    dcs_counter #(.WIDTH(W), .DUAL_EDGE(1'b1), .CHUNK(CH)) u0 (
        .clk(clk), .clr(clr), .snap(snap), .cnt_o(cnt0), .cnt_rdy_o(rdy0));
    dcs_counter #(.WIDTH(W), .DUAL_EDGE(1'b0), .CHUNK(CH)) u1 (
        .clk(clk), .clr(clr), .snap(snap), .cnt_o(cnt1), .cnt_rdy_o(rdy1));

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    bit    live  = 1'b0;
    string tag   = "R9";

    // Behavioural reference: [0] dual-edge instance, [1] single-edge instance.
    logic [W-1:0] m_ref [2];
    logic [W-1:0] m_cap [2];
    logic [W-1:0] m_out [2];
    bit           m_busy[2];
    bit           m_show[2];
    int           m_left[2];

    initial begin
        for (int m = 0; m < 2; m++) begin
            m_ref[m] = '0; m_cap[m] = '0; m_out[m] = '0;
            m_busy[m] = 1'b0; m_show[m] = 1'b0; m_left[m] = 0;
        end
    end

    always @(posedge clk) begin
        for (int m = 0; m < 2; m++) begin
            if (clr) begin
                m_busy[m] = 1'b0; m_show[m] = 1'b0; m_left[m] = 0; m_out[m] = '0;
            end else if (m_show[m]) begin
                m_show[m] = 1'b0; m_busy[m] = 1'b0;
            end else if (m_busy[m]) begin
                m_left[m] = m_left[m] - 1;
                if (m_left[m] == 0) begin
                    m_show[m] = 1'b1;
                    m_out[m]  = m_cap[m];
                end
            end else if (snap) begin
                m_busy[m] = 1'b1; m_left[m] = NCH; m_cap[m] = m_ref[m];
            end
            if (clr) m_ref[m] = '0;
            else     m_ref[m] = m_ref[m] + 1'b1;
        end
    end

    always @(negedge clk) begin
        if (clr) m_ref[0] = '0;
        else     m_ref[0] = m_ref[0] + 1'b1;
    end

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Compare against the reference on every clock, between edges.
    always @(posedge clk) begin
        #3;
        if (live && !done) begin
            chk(tag, {{(W-1){1'b0}}, rdy0}, {{(W-1){1'b0}}, m_show[0]});
            chk(tag, {{(W-1){1'b0}}, rdy1}, {{(W-1){1'b0}}, m_show[1]});
            chk(tag, cnt0, m_out[0]);
            chk(tag, cnt1, m_out[1]);
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic snap_read(output logic [W-1:0] a, output logic [W-1:0] b);
        snap = 1'b1;
        step();
        snap = 1'b0;
        repeat (NCH) step();
        #1;
        chk("R7", {{(W-1){1'b0}}, rdy0}, 1);
        chk("R7", {{(W-1){1'b0}}, rdy1}, 1);
        a = cnt0;
        b = cnt1;
        step();
    endtask

    task automatic clr_snap(int n, output logic [W-1:0] a, output logic [W-1:0] b);
        clr = 1'b1;
        step();
        clr = 1'b0;
        repeat (n - 1) step();
        snap_read(a, b);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] a0, a1, b0, b1;
        int pulses;

        // Reset state (R9).
        repeat (3) step();
        #1;
        chk("R9", cnt0, 0);
        chk("R9", cnt1, 0);
        chk("R9", {{(W-1){1'b0}}, rdy0}, 0);
        live = 1'b1;
        step();

        // First counts after clear (R4, R6).
        tag = "R4";
        clr_snap(1, a0, a1);
        chk("R4", a0, 1);
        chk("R6", a1, 0);

        // Pending carries resolved (R3), single-edge rate (R2).
        tag = "R3";
        clr_snap(128, a0, a1);
        chk("R3", a0, 255);
        chk("R2", a1, 127);

        // Rate over a known distance (R1, R2).
        tag = "R1";
        repeat (10) step();
        snap_read(b0, b1);
        chk("R1", b0 - a0, W'(2 * (NCH + 2 + 10)));
        chk("R2", b1 - a1, W'(NCH + 2 + 10));

        // Bit toggle period (R10): captures 32 clocks apart.
        tag = "R10";
        repeat (32 - (NCH + 2)) step();
        snap_read(a0, a1);
        repeat (32 - (NCH + 2)) step();
        snap_read(b0, b1);
        chk("R10", W'(b0[5:0]), W'(a0[5:0]));
        chk("R10", W'(b0[6] ^ a0[6]), 1);
        chk("R10", W'(b1[4:0]), W'(a1[4:0]));
        chk("R10", W'(b1[5] ^ a1[5]), 1);

        // Strobe held high: busy strobes ignored (R8).
        tag = "R8";
        pulses = 0;
        snap = 1'b1;
        for (int i = 0; i < 26; i++) begin
            if (i == 20) snap = 1'b0;
            step();
            #1;
            if (rdy0) pulses++;
        end
        chk("R8", W'(pulses), 4);

        // Clear during a resolve (R9).
        tag = "R9";
        snap = 1'b1;
        step();
        snap = 1'b0;
        step();
        clr = 1'b1;
        step();
        clr = 1'b0;
        pulses = 0;
        for (int i = 0; i < NCH + 2; i++) begin
            step();
            #1;
            if (rdy0 || rdy1) pulses++;
        end
        chk("R9", W'(pulses), 0);
        chk("R9", cnt0, 0);

        // Wrap (R5): 4099 edges modulo 4096.
        tag = "R5";
        clr_snap(2050, a0, a1);
        chk("R5", a0, 3);
        clr_snap(4100, a0, a1);
        chk("R5", a1, 3);

        step();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule